// File: doc/BRIEF.md
# DC-Only Inverse Transform Adder

This block reconstructs a prediction block whose residual holds a DC term and nothing else. A start pulse captures a signed DC coefficient and a shape code. The block then scales the coefficient through two integer stages, one for each transform dimension. The result is a single signed offset, which is added to every pixel of the co-located prediction block. Each sum is clamped to the 8-bit pixel range.

Prediction pixels arrive in raster order on a valid/ready stream, and reconstructed pixels leave in the same order. The input ready is the output ready gated by the block's run state, so one pixel passes per cycle with no internal buffering. The final pixel of the block is flagged, and the block then returns to idle and waits for the next start.

Top module: `dc_recon_adder`

## Requirements
- R1: After reset, out_valid, out_last and pred_ready are all low.
- R2: Shape code is two bits: bit 1 set means 4 pixels wide (clear means 8), bit 0 set means 4 rows tall (clear means 8). For shape 2'b00 the offset is s=(3*dc+1)>>1, then (3*s+16)>>5, with arithmetic shifts.
- R3: For shape 2'b01 (8 wide, 4 tall) the offset is s=(3*dc+1)>>1, then (17*s+64)>>7.
- R4: For shape 2'b10 (4 wide, 8 tall) the offset is s=(17*dc+4)>>3, then (12*s+64)>>7.
- R5: For shape 2'b11 (4x4) the offset is s=(17*dc+4)>>3, then (17*s+64)>>7.
- R6: Every output pixel equals its prediction pixel plus the offset, clamped to a maximum of 255.
- R7: With a negative offset, results clamp at 0 and never wrap.
- R8: The block passes exactly 64, 32, 32 or 16 pixels for shapes 00, 01, 10, 11. out_last is high only on the final pixel, and pred_ready is low after it.
- R9: A start pulse that arrives while a block is being processed is ignored: the offset and the pixel count are unchanged.
- R10: pred_ready stays low in the cycle after the start edge and may first be high in the second cycle after it.
- R11: While out_ready is low, pred_ready is low and no pixel is consumed.
- R12: No intermediate stage overflows for any 16-bit signed DC, including -32768 and 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a block; sampled only when idle |
| dc_in | input | 16 | Signed DC coefficient |
| shape | input | 2 | Bit 1: 4 wide; bit 0: 4 tall |
| pred_valid | input | 1 | Prediction pixel valid |
| pred_ready | output | 1 | Prediction pixel accepted this cycle |
| pred_pix | input | 8 | Prediction pixel |
| out_valid | output | 1 | Reconstructed pixel valid |
| out_ready | input | 1 | Downstream accepts pixel |
| out_pix | output | 8 | Reconstructed pixel |
| out_last | output | 1 | Final pixel of the block |

## Verification
The bench builds the block with its default widths: a 16-bit coefficient, 8-bit pixels and an offset path 24 bits wide. At these widths the DC extremes -32768 and 32767 can be applied directly. The full 0..255 pixel range can then be pushed into both clamps. All four shapes are run with positive and negative coefficients, with downstream stalls and with a stray start in the middle of a block. Every pixel is compared against offsets the bench computes itself from the formulas.

// File: rtl/dc_recon_pkg.sv
// Shared definitions for the DC-only reconstruction adder.
// Assumes shape bit 1 selects the narrow width and bit 0 the short height.
package dc_recon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCALE = 2'd1,
        ST_RUN   = 2'd2
    } run_state_t;

    localparam int DIM_FULL = 8;
    localparam int DIM_HALF = 4;
endpackage

// File: rtl/dc_scale_stage.sv
// One scaling stage: y = (M*x + R) >>> S, with the coefficient set picked by sel.
// Assumes ACC_W is wide enough that M*x cannot overflow for the inputs used.
module dc_scale_stage #(
    parameter int ACC_W = 24,
    parameter int MUL0  = 3,
    parameter int RND0  = 1,
    parameter int SHF0  = 1,
    parameter int MUL1  = 17,
    parameter int RND1  = 4,
    parameter int SHF1  = 3
) (
    input  logic                    sel,
    input  logic signed [ACC_W-1:0] x,
    output logic signed [ACC_W-1:0] y
);
    localparam logic signed [ACC_W-1:0] M0 = ACC_W'(MUL0);
    localparam logic signed [ACC_W-1:0] M1 = ACC_W'(MUL1);
    localparam logic signed [ACC_W-1:0] A0 = ACC_W'(RND0);
    localparam logic signed [ACC_W-1:0] A1 = ACC_W'(RND1);

    logic signed [ACC_W-1:0] prod;

    // Multiply, add rounding term, arithmetic shift for the selected set.
    always_comb begin
        if (sel) begin
            prod = x * M1 + A1;
            y    = prod >>> SHF1;
        end else begin
            prod = x * M0 + A0;
            y    = prod >>> SHF0;
        end
    end
endmodule

// File: rtl/pix_sat_add.sv
// Adds a signed offset to an unsigned pixel and clamps to [0, 2^PIX_W-1].
// Assumes ACC_W > PIX_W + 1 so the sum itself cannot wrap.
module pix_sat_add #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 24
) (
    input  logic        [PIX_W-1:0] pix,
    input  logic signed [ACC_W-1:0] ofs,
    output logic        [PIX_W-1:0] res
);
    localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << PIX_W) - 1);

    logic signed [ACC_W-1:0] sum;

    // Widen, add, then clamp to the pixel range.
    always_comb begin
        sum = $signed({{(ACC_W-PIX_W){1'b0}}, pix}) + ofs;
        if (sum < 0)
            res = '0;
        else if (sum > PMAX)
            res = '1;
        else
            res = sum[PIX_W-1:0];
    end
endmodule

// File: rtl/dc_recon_adder.sv
// DC-only inverse transform adder. A start pulse in idle captures dc_in and
// shape; the first stage result registers at that edge, the second at the
// next, then pixels stream through one per cycle with a clamped add.
// Assumes the producer holds pred_pix stable while pred_valid is high.
module dc_recon_adder
    import dc_recon_pkg::*;
#(
    parameter int DC_W  = 16,
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DC_W-1:0]  dc_in,
    input  logic [1:0]       shape,
    input  logic             pred_valid,
    output logic             pred_ready,
    input  logic [PIX_W-1:0] pred_pix,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_last
);
    localparam int ACC_W  = DC_W + 8;
    localparam int MAXPIX = DIM_FULL * DIM_FULL;
    localparam int CNT_W  = $clog2(MAXPIX + 1);

    run_state_t              state;
    logic [1:0]              shape_q;
    logic signed [ACC_W-1:0] dc_ext, s1_comb, s1_q, s2_comb, s2_q;
    logic [CNT_W-1:0]        cnt, blk_len;
    logic                    fire, at_end;

    assign dc_ext = ACC_W'($signed(dc_in));

    // Width stage: 8 wide uses (3,1,>>1), 4 wide uses (17,4,>>3).
    dc_scale_stage #(.ACC_W(ACC_W), .MUL0(3), .RND0(1), .SHF0(1),
                     .MUL1(17), .RND1(4), .SHF1(3))
        u_stage_w (.sel(shape[1]), .x(dc_ext), .y(s1_comb));

    // Height stage: 8 tall uses (3,16,>>5), 4 tall uses (17,64,>>7).
    dc_scale_stage #(.ACC_W(ACC_W), .MUL0(3), .RND0(16), .SHF0(5),
                     .MUL1(17), .RND1(64), .SHF1(7))
        u_stage_h (.sel(shape_q[0]), .x(s1_q), .y(s2_comb));

    pix_sat_add #(.PIX_W(PIX_W), .ACC_W(ACC_W))
        u_sat (.pix(pred_pix), .ofs(s2_q), .res(out_pix));

    // Pixel count of the captured shape.
    always_comb begin
        blk_len = CNT_W'((shape_q[1] ? DIM_HALF : DIM_FULL) *
                         (shape_q[0] ? DIM_HALF : DIM_FULL));
    end

    assign pred_ready = (state == ST_RUN) && out_ready;
    assign out_valid  = (state == ST_RUN) && pred_valid;
    assign fire       = out_valid && out_ready;
    assign at_end     = (cnt == blk_len - 1'b1);
    assign out_last   = out_valid && at_end;

    // Sequencer: capture, scale, then count pixels to the end of block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shape_q <= '0;
            s1_q    <= '0;
            s2_q    <= '0;
            cnt     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    shape_q <= shape;
                    s1_q    <= s1_comb;
                    state   <= ST_SCALE;
                end
                ST_SCALE: begin
                    s2_q  <= s2_comb;
                    cnt   <= '0;
                    state <= ST_RUN;
                end
                ST_RUN: if (fire) begin
                    cnt <= cnt + 1'b1;
                    if (at_end) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dc_recon_adder_chk.sv
// Port-level protocol checks for dc_recon_adder, bound to every instance.
module dc_recon_adder_chk (
    input logic clk,
    input logic rst_n,
    input logic pred_valid,
    input logic pred_ready,
    input logic out_valid,
    input logic out_ready,
    input logic out_last
);
    // R1: first cycle out of reset is idle
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pred_ready && !out_valid));

    // R11: no consumption while downstream stalls
    a_r11_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !pred_ready);

    // R8: last only on a valid pixel
    a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R8: idle after the last pixel is taken
    a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready) |=> !pred_ready);

    // R11: output valid only with a valid input pixel
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pred_valid);
endmodule

bind dc_recon_adder dc_recon_adder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_ready(pred_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last)
);

// File: tb/dc_recon_adder_test.sv
module dc_recon_adder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0, start = 0;
    logic [15:0] dc_in = 0;
    logic [1:0]  shape = 0;
    logic        pred_valid = 0, out_ready = 0;
    logic [7:0]  pred_pix = 0;
    logic        pred_ready, out_valid, out_last;
    logic [7:0]  out_pix;
    int checks = 0, fails = 0;
    bit done = 0;

    dc_recon_adder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dc_in(dc_in), .shape(shape),
        .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_pix(pred_pix),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .out_last(out_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ref_ofs(input int dc, input logic [1:0] sh);
        int s;
        if (!sh[1]) s = (3*dc + 1) >>> 1;
        else        s = (17*dc + 4) >>> 3;
        if (!sh[0]) return (3*s + 16) >>> 5;
        else        return (17*s + 64) >>> 7;
    endfunction

    function automatic int clamp8(input int v);
        return v < 0 ? 0 : (v > 255 ? 255 : v);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one block; stall throttles out_ready, poke sends a stray start mid-block.
    task automatic run_block(input int dc, input logic [1:0] sh, input int seed,
                             input bit stall, input bit poke, input string req);
        int n, ofs, idx, cyc;
        n   = (sh[1] ? 4 : 8) * (sh[0] ? 4 : 8);
        ofs = ref_ofs(dc, sh);
        @(negedge clk);
        start = 1; dc_in = 16'(dc); shape = sh; out_ready = 1; pred_valid = 1;
        @(negedge clk);
        start = 0; dc_in = 16'(-dc); shape = ~sh;
        #1 check(pred_ready == 0, "R10", pred_ready, 0);
        idx = 0; cyc = 0;
        while (idx < n) begin
            @(negedge clk);
            out_ready = stall ? (cyc % 3 != 1) : 1'b1;
            start     = poke && (idx == n/2);
            pred_pix  = 8'((idx*37 + seed) & 255);
            #1;
            if (out_ready) begin
                check(out_pix == 8'(clamp8(int'(pred_pix) + ofs)), req,
                      out_pix, clamp8(int'(pred_pix) + ofs));
                check(out_last == (idx == n-1), "R8", out_last, idx == n-1);
                if (!pred_ready) check(0, "R10", pred_ready, 1);
                idx++;
            end else begin
                check(pred_ready == 0, "R11", pred_ready, 0);
            end
            cyc++;
        end
        @(negedge clk);
        start = 0; out_ready = 1;
        #1 check(pred_ready == 0 && out_valid == 0, "R8", pred_ready, 0);
    endtask

    task automatic t_reset();
        #1 check(!out_valid && !pred_ready && !out_last, "R1", out_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        run_block(100, 2'b00, 0, 0, 0, "R2");
        run_block(-100, 2'b01, 5, 0, 0, "R3");
        run_block(777, 2'b10, 11, 1, 0, "R4");
        run_block(-555, 2'b11, 200, 0, 0, "R5");
        run_block(2000, 2'b00, 250, 0, 0, "R6");
        run_block(-2000, 2'b11, 3, 1, 0, "R7");
        run_block(300, 2'b01, 9, 0, 1, "R9");
        run_block(32767, 2'b11, 1, 0, 0, "R12");
        run_block(-32768, 2'b00, 255, 0, 0, "R12");
        run_block(-32768, 2'b10, 128, 1, 0, "R12");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule